// File: doc/BRIEF.md
# Dual-Bank Integer Multiply/Divide Unit

This block is the 32-bit integer multiply/divide engine of a simple in-order core. It holds two independent high/low result pairs, called bank 0 and bank 1. Each command names one bank, and no command reads or writes the other bank. The unit accepts signed and unsigned multiply and divide operations, plus moves into and out of either half of either bank. Commands arrive on a valid/ready handshake.

A multiply completes in one registered cycle. It writes the 64-bit product into the selected bank. When the command carries a nonzero destination index, it also returns the low product word for general-register writeback.

A divide runs on a shared iterative unit for 33 cycles and then commits the quotient to LO and the remainder to HI. While the divide runs, `busy` is high. During that time, commands aimed at the dividing bank, and any second divide, are held off through `cmd_ready`. Commands to the other bank keep flowing. No divide ever reports an overflow or an error. The most-negative dividend divided by minus one, and division by zero, both give fixed results.

Top module: `muldiv_dual`

## Requirements
- R1: After reset, all four result registers read zero, and `busy`, `wb_valid` and `rd_valid` are low.
- R2: Opcode 0 (signed) and opcode 1 (unsigned) multiply `cmd_rs` by `cmd_rt` into a 64-bit product. The upper word goes to HI and the lower word to LO of bank `cmd_bank`, and both are visible from the cycle after acceptance. For example, 0xFFFFFFFF×0xFFFFFFFF unsigned gives 0xFFFFFFFE_00000001, and 0x80000000×0x80000000 signed gives 0x40000000_00000000.
- R3: A multiply with nonzero `cmd_dst` pulses `wb_valid` for one cycle, starting the cycle after acceptance. During that pulse `wb_idx` equals `cmd_dst` and `wb_data` equals the new LO. A multiply with `cmd_dst`=0 leaves `wb_valid` low.
- R4: Opcode 2 is signed divide. LO gets the quotient truncated toward zero, and HI gets the remainder, which carries the dividend's sign.
- R5: Signed divide of 0x80000000 by 0xFFFFFFFF gives LO=0x80000000 and HI=0, with no error indication.
- R6: Opcode 3 is unsigned divide. LO gets the unsigned quotient and HI the unsigned remainder; for example, 77773/101 gives 770 remainder 3.
- R7: Any divide by zero, signed or unsigned, takes the normal time and leaves LO=0xFFFFFFFF and HI=the dividend unchanged.
- R8: Opcode 4 loads `cmd_rs` into LO and opcode 5 loads it into HI. Opcode 6 reads LO and opcode 7 reads HI. A read returns the value on `rd_data`, with a one-cycle `rd_valid` pulse, in the cycle after acceptance.
- R9: A command to one bank never changes the other bank. This holds for a divide and a command to the other bank that take effect at the same clock edge.
- R10: `busy` is high for exactly 33 cycles after a divide is accepted. The result becomes visible in the cycle after `busy` falls.
- R11: While `busy` is high, `cmd_ready` is low for any divide and for every command addressed to the dividing bank. Commands to the other bank are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 3 | Operation code (see R2, R4, R6, R8) |
| cmd_bank | input | 1 | Result bank select |
| cmd_rs | input | 32 | First operand / move-to value |
| cmd_rt | input | 32 | Second operand |
| cmd_dst | input | 5 | Multiply writeback register index, 0 = none |
| busy | output | 1 | Divide in progress |
| wb_valid | output | 1 | Multiply low-word writeback pulse |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value |
| rd_valid | output | 1 | Move-from result pulse |
| rd_data | output | 32 | Move-from result value |

## Verification
A divide's commit and a multiply or move on the other bank can land on the same clock edge. Both write the bank storage in that cycle. The bench starts a divide on bank 0 and counts 33 cycles so that a writeback multiply to bank 1 is accepted in the exact commit cycle. It then reads all four registers and checks that each holds only its own operation's result. In the same way, a read of the busy bank is offered mid-divide and must see `cmd_ready` low, while a command to the idle bank goes through.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MULS = 3'd0,
    OP_MULU = 3'd1,
    OP_DIVS = 3'd2,
    OP_DIVU = 3'd3,
    OP_MTLO = 3'd4,
    OP_MTHI = 3'd5,
    OP_MFLO = 3'd6,
    OP_MFHI = 3'd7
  } md_op_e;
endpackage

// File: rtl/muldiv_mult.sv
module muldiv_mult #(
  parameter int DW = 32
) (
  input  logic            sgn,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   prod_hi,
  output logic [DW-1:0]   prod_lo
);
  function automatic logic [2*DW-1:0] full_product(
    input logic [DW-1:0] x, input logic [DW-1:0] y, input logic s);
    logic signed [DW:0]     ex;
    logic signed [DW:0]     ey;
    logic signed [2*DW+1:0] p;
    ex = $signed({x[DW-1] & s, x});
    ey = $signed({y[DW-1] & s, y});
    p  = ex * ey;
    return p[2*DW-1:0];
  endfunction

  logic [2*DW-1:0] prod;
  assign prod    = full_product(a, b, sgn);
  assign prod_hi = prod[2*DW-1:DW];
  assign prod_lo = prod[DW-1:0];
endmodule

// File: rtl/muldiv_divider.sv
module muldiv_divider #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sgn,
  input  logic [DW-1:0] dvd,
  input  logic [DW-1:0] dvs,
  output logic          running,
  output logic          done,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(DW);

  function automatic logic [DW-1:0] magnitude(input logic [DW-1:0] x, input logic s);
    return (s && x[DW-1]) ? (~x + 1'b1) : x;
  endfunction

  logic          run_q, done_q, negq_q, negr_q, zero_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   part_q;
  logic [DW-1:0] acc_q, dvs_q, dvd_q;
  logic [DW:0]   shifted, diff;
  logic          fits, last_step;

  assign shifted   = {part_q[DW-1:0], acc_q[DW-1]};
  assign diff      = shifted - {1'b0, dvs_q};
  assign fits      = ~diff[DW];
  assign last_step = run_q && (cnt_q == CW'(DW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      zero_q <= 1'b0;
      cnt_q  <= '0;
      part_q <= '0;
      acc_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
      part_q <= '0;
      acc_q  <= magnitude(dvd, sgn);
      dvs_q  <= magnitude(dvs, sgn);
      negq_q <= sgn & (dvd[DW-1] ^ dvs[DW-1]);
      negr_q <= sgn & dvd[DW-1];
      zero_q <= (dvs == '0);
      dvd_q  <= dvd;
    end else if (run_q) begin
      part_q <= fits ? diff : shifted;
      acc_q  <= {acc_q[DW-2:0], fits};
      cnt_q  <= cnt_q + 1'b1;
      if (last_step) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign running = run_q;
  assign done    = done_q;
  assign quo = zero_q ? '1    : (negq_q ? (~acc_q + 1'b1) : acc_q);
  assign rem = zero_q ? dvd_q : (negr_q ? (~part_q[DW-1:0] + 1'b1) : part_q[DW-1:0]);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running && !done);
endmodule

// File: rtl/muldiv_bankfile.sv
module muldiv_bankfile #(
  parameter int DW    = 32,
  parameter int NBANK = 2,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we_hi,
  input  logic          cmd_we_lo,
  input  logic [BW-1:0] cmd_bank,
  input  logic [DW-1:0] cmd_hi,
  input  logic [DW-1:0] cmd_lo,
  input  logic          div_we,
  input  logic [BW-1:0] div_bank,
  input  logic [DW-1:0] div_hi,
  input  logic [DW-1:0] div_lo,
  input  logic [BW-1:0] rd_bank,
  output logic [DW-1:0] rd_hi,
  output logic [DW-1:0] rd_lo
);
  logic [DW-1:0] hi_q [NBANK];
  logic [DW-1:0] lo_q [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic sel_cmd, sel_div;
    assign sel_cmd = (cmd_bank == BW'(g));
    assign sel_div = div_we && (div_bank == BW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (sel_div) begin
        hi_q[g] <= div_hi;
        lo_q[g] <= div_lo;
      end else if (sel_cmd) begin
        if (cmd_we_hi) hi_q[g] <= cmd_hi;
        if (cmd_we_lo) lo_q[g] <= cmd_lo;
      end
    end
  end

  assign rd_hi = hi_q[rd_bank];
  assign rd_lo = lo_q[rd_bank];

  assert_bank_isolation_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_we && (cmd_we_hi || cmd_we_lo)) |-> (cmd_bank != div_bank));
endmodule

// File: rtl/muldiv_dual.sv
module muldiv_dual #(
  parameter int DW    = 32,
  parameter int NBANK = 2,
  parameter int IDXW  = 5,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CW   = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [BW-1:0]   cmd_bank,
  input  logic [DW-1:0]   cmd_rs,
  input  logic [DW-1:0]   cmd_rt,
  input  logic [IDXW-1:0] cmd_dst,
  output logic            busy,
  output logic            wb_valid,
  output logic [IDXW-1:0] wb_idx,
  output logic [DW-1:0]   wb_data,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data
);
  import muldiv_pkg::*;

  md_op_e op;
  logic   fire, is_mul, is_div, is_mf, mul_sgn;
  logic   div_run, div_done;
  logic [BW-1:0] div_bank_q;
  logic [DW-1:0] prod_hi, prod_lo, div_quo, div_rem, rd_hi, rd_lo;
  logic   cmd_we_hi, cmd_we_lo;
  logic [DW-1:0] cmd_hi, cmd_lo;

  assign op      = md_op_e'(cmd_op);
  assign is_mul  = (op == OP_MULS) || (op == OP_MULU);
  assign is_div  = (op == OP_DIVS) || (op == OP_DIVU);
  assign is_mf   = (op == OP_MFLO) || (op == OP_MFHI);
  assign mul_sgn = (op == OP_MULS);

  assign busy      = div_run | div_done;
  assign cmd_ready = !busy || (!is_div && (cmd_bank != div_bank_q));
  assign fire      = cmd_valid && cmd_ready;

  muldiv_mult #(.DW(DW)) u_mult (
    .sgn(mul_sgn), .a(cmd_rs), .b(cmd_rt), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  muldiv_divider #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(fire && is_div), .sgn(op == OP_DIVS),
    .dvd(cmd_rs), .dvs(cmd_rt), .running(div_run), .done(div_done),
    .quo(div_quo), .rem(div_rem)
  );

  always_comb begin
    cmd_we_hi = 1'b0;
    cmd_we_lo = 1'b0;
    cmd_hi    = prod_hi;
    cmd_lo    = prod_lo;
    if (fire) begin
      case (op)
        OP_MULS, OP_MULU: begin cmd_we_hi = 1'b1; cmd_we_lo = 1'b1; end
        OP_MTLO: begin cmd_we_lo = 1'b1; cmd_lo = cmd_rs; end
        OP_MTHI: begin cmd_we_hi = 1'b1; cmd_hi = cmd_rs; end
        default: ;
      endcase
    end
  end

  muldiv_bankfile #(.DW(DW), .NBANK(NBANK)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .cmd_we_hi(cmd_we_hi), .cmd_we_lo(cmd_we_lo), .cmd_bank(cmd_bank),
    .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .div_we(div_done), .div_bank(div_bank_q), .div_hi(div_rem), .div_lo(div_quo),
    .rd_bank(cmd_bank), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_bank_q <= '0;
      wb_valid   <= 1'b0;
      wb_idx     <= '0;
      wb_data    <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (fire && is_div) div_bank_q <= cmd_bank;
      wb_valid <= fire && is_mul && (cmd_dst != '0);
      if (fire && is_mul) begin
        wb_idx  <= cmd_dst;
        wb_data <= prod_lo;
      end
      rd_valid <= fire && is_mf;
      if (fire && is_mf) rd_data <= (op == OP_MFHI) ? rd_hi : rd_lo;
    end
  end

  // cycle counter watching the divide window for the latency check
  logic [CW+1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lat_q <= '0;
    else if (fire && is_div)  lat_q <= (CW+2)'(1);
    else if (busy)            lat_q <= lat_q + 1'b1;
  end

  assert_div_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (lat_q == (CW+2)'(DW+1)));
  assert_wb_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_idx != '0));
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_mf) |=> rd_valid);
  assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && is_mf) |=> !rd_valid);
  assert_busy_bank_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cmd_we_hi || cmd_we_lo)) |-> (cmd_bank != div_bank_q));
endmodule

// File: tb/test_muldiv_dual.sv
module test_muldiv_dual;
  localparam logic [2:0] MULS = 3'd0, MULU = 3'd1, DIVS = 3'd2, DIVU = 3'd3,
                         MTLO = 3'd4, MTHI = 3'd5, MFLO = 3'd6, MFHI = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic        cmd_bank = 1'b0;
  logic [31:0] cmd_rs = '0, cmd_rt = '0;
  logic [4:0]  cmd_dst = '0;
  logic        busy, wb_valid, rd_valid;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data, rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  muldiv_dual i_muldiv_dual (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_rs(cmd_rs), .cmd_rt(cmd_rt),
    .cmd_dst(cmd_dst), .busy(busy), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_data(wb_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, wait for ready, return one step after the accepting edge
  task automatic send(input logic [2:0] op, input logic bank, input logic [31:0] rs,
                      input logic [31:0] rt, input logic [4:0] dst);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank;
    cmd_rs = rs; cmd_rt = rt; cmd_dst = dst;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic read_pair(input logic bank, output logic [31:0] hi, output logic [31:0] lo);
    send(MFHI, bank, '0, '0, '0);
    chk("R8 rd_valid", {63'd0, rd_valid}, 64'd1);
    hi = rd_data;
    send(MFLO, bank, '0, '0, '0);
    lo = rd_data;
  endtask

  task automatic wait_idle();
    while (busy) begin @(posedge clk); #1; end
  endtask

  task automatic t_reset();
    logic [31:0] h, l;
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 wb_valid", {63'd0, wb_valid}, 64'd0);
    chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    read_pair(1'b0, h, l); chk("R1 bank0", {h, l}, 64'd0);
    read_pair(1'b1, h, l); chk("R1 bank1", {h, l}, 64'd0);
  endtask

  task automatic mul_case(input logic sg, input logic bank, input logic [31:0] a,
                          input logic [31:0] b, input logic [4:0] dst);
    logic [63:0] exp;
    logic [31:0] h, l;
    if (sg) exp = 64'(longint'($signed(a)) * longint'($signed(b)));
    else    exp = {32'd0, a} * {32'd0, b};
    send(sg ? MULS : MULU, bank, a, b, dst);
    chk("R3 wb_valid", {63'd0, wb_valid}, {63'd0, dst != 0});
    if (dst != 0) begin
      chk("R3 wb_idx", {59'd0, wb_idx}, {59'd0, dst});
      chk("R3 wb_data", {32'd0, wb_data}, {32'd0, exp[31:0]});
    end
    read_pair(bank, h, l);
    chk("R2 product", {h, l}, exp);
  endtask

  task automatic t_multiply();
    mul_case(1'b1, 1'b0, 32'd12207031, 32'd305175781, 5'd7);
    mul_case(1'b1, 1'b1, -32'sd77773, 32'd99991, 5'd0);
    mul_case(1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31);
    chk("R2 unsigned max", 64'hFFFF_FFFE_0000_0001,
        {32'd0, 32'hFFFF_FFFF} * {32'd0, 32'hFFFF_FFFF});
    mul_case(1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, 5'd1);
    mul_case(1'b1, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 5'd2);
  endtask

  task automatic div_case(input string req, input logic sg, input logic bank,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] eq, input logic [31:0] er);
    logic [31:0] h, l;
    send(sg ? DIVS : DIVU, bank, a, b, '0);
    wait_idle();
    read_pair(bank, h, l);
    chk(req, {h, l}, {er, eq});
  endtask

  task automatic t_divide();
    div_case("R6 unsigned", 1'b0, 1'b0, 32'd77773, 32'd101, 32'd770, 32'd3);
    div_case("R6 unsigned big", 1'b0, 1'b1, 32'hFFFF_FFF0, 32'd7,
             32'hFFFF_FFF0 / 32'd7, 32'hFFFF_FFF0 % 32'd7);
    div_case("R4 neg dividend", 1'b1, 1'b0, -32'sd77773, 32'd101, -32'sd770, -32'sd3);
    div_case("R4 neg divisor", 1'b1, 1'b1, 32'd19, -32'sd17, -32'sd1, 32'd2);
    div_case("R4 both neg", 1'b1, 1'b0, -32'sd19, -32'sd17, 32'd1, -32'sd2);
    div_case("R5 min by -1", 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'd0);
    div_case("R7 unsigned zero", 1'b0, 1'b0, 32'd12345, 32'd0, 32'hFFFF_FFFF, 32'd12345);
    div_case("R7 signed zero", 1'b1, 1'b1, -32'sd5, 32'd0, 32'hFFFF_FFFF, -32'sd5);
  endtask

  task automatic t_moves();
    logic [31:0] h, l;
    send(MTLO, 1'b0, 32'hA5A5_0001, '0, '0);
    send(MTHI, 1'b0, 32'h5A5A_0002, '0, '0);
    send(MTLO, 1'b1, 32'h0000_1111, '0, '0);
    send(MTHI, 1'b1, 32'h0000_2222, '0, '0);
    read_pair(1'b0, h, l); chk("R8 bank0 moves", {h, l}, 64'h5A5A_0002_A5A5_0001);
    read_pair(1'b1, h, l); chk("R8 bank1 moves", {h, l}, 64'h0000_2222_0000_1111);
    send(MULU, 1'b0, 32'd3, 32'd5, 5'd9);
    read_pair(1'b1, h, l); chk("R9 bank1 untouched by mul", {h, l}, 64'h0000_2222_0000_1111);
    send(DIVU, 1'b1, 32'd100, 32'd7, '0);
    wait_idle();
    read_pair(1'b0, h, l); chk("R9 bank0 untouched by div", {h, l}, 64'd15);
  endtask

  task automatic t_latency_and_stall();
    int n;
    logic [31:0] h, l;
    send(DIVU, 1'b0, 32'd1000, 32'd3, '0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = MFLO; cmd_bank = 1'b0; #1;
    chk("R11 same-bank read stalled", {63'd0, cmd_ready}, 64'd0);
    cmd_op = DIVU; cmd_bank = 1'b1; #1;
    chk("R11 second divide stalled", {63'd0, cmd_ready}, 64'd0);
    cmd_op = MULU; cmd_bank = 1'b1; #1;
    chk("R11 other bank ready", {63'd0, cmd_ready}, 64'd1);
    cmd_valid = 1'b0;
    // measure from the acceptance cycle onward
    send(DIVS, 1'b0, -32'sd1000, 32'd3, '0);
    wait_idle();
    send(DIVU, 1'b0, 32'd50, 32'd6, '0);
    n = 0;
    while (busy) begin n++; @(posedge clk); #1; end
    chk("R10 busy cycles", 64'(n), 64'd33);
    read_pair(1'b0, h, l); chk("R10 result after busy", {h, l}, {32'd2, 32'd8});
  endtask

  task automatic t_same_edge();
    logic [31:0] h, l;
    send(DIVU, 1'b0, 32'd77773, 32'd101, '0);
    repeat (32) @(posedge clk);
    send(MULU, 1'b1, 32'd17, 32'd19, 5'd4);
    chk("R9 commit edge", {63'd0, busy}, 64'd0);
    chk("R3 wb on commit edge", {27'd0, wb_valid, wb_idx, wb_data}, {27'd0, 1'b1, 5'd4, 32'd323});
    read_pair(1'b0, h, l); chk("R9 div bank", {h, l}, {32'd3, 32'd770});
    read_pair(1'b1, h, l); chk("R9 mul bank", {h, l}, 64'd323);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_multiply();
    t_divide();
    t_moves();
    t_latency_and_stall();
    t_same_edge();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule